// File: doc/BRIEF.md
# Registered bidirectional bus transceiver

This block links two bidirectional data ports, A and B, and holds one storage register per port. Port A's register is loaded on a rising edge of its own capture clock, and port B's register is loaded on a rising edge of a second, independent clock. Neither clock is qualified by any control input, so either register can be loaded at any moment, including while both ports are released.

An active-low output enable and a direction input decide which port, if any, the block drives. A per-direction source select then decides what the driven port shows: either the live data arriving at the opposite port, or the contents of the opposite port's storage register. Each port is modelled as three separate signals rather than as a tristate net: an input vector, an output vector and a drive-enable flag.

A register always captures the value that is actually present on its port. That is the external input while the port is released, and the block's own output while the port is driven. A synchronous active-low reset clears each register on that register's own clock edge.

Top module: `regbus_xcvr`

## Requirements
- R1: While `oe_n` is 1, both `a_oe` and `b_oe` are 0 and both `a_out` and `b_out` read all zeros, whatever the values of `dir`, `sel_ab` and `sel_ba`.
- R2: While `oe_n` is 0, `dir` = 0 drives port A only (`a_oe`=1, `b_oe`=0) and `dir` = 1 drives port B only (`b_oe`=1, `a_oe`=0).
- R3: When port B is driven, `b_out` equals `a_in` if `sel_ab` is 0, and equals the A register if `sel_ab` is 1. `sel_ba` has no effect on `b_out`.
- R4: When port A is driven, `a_out` equals `b_in` if `sel_ba` is 0, and equals the B register if `sel_ba` is 1. `sel_ab` has no effect on `a_out`.
- R5: A rising edge of `clk_ab` loads the A register from port A. A rising edge of `clk_ba` loads the B register from port B. Each clock leaves the other register unchanged.
- R6: Loads happen for every setting of `oe_n`, `dir`, `sel_ab` and `sel_ba`, including while both ports are released.
- R7: Passing live data through (select at 0), including changes on the live input, leaves both registers unchanged when no capture edge occurs.
- R8: While a port is driven, its register captures the value the block drives onto that port and ignores the external input vector of that port.
- R9: `rst_n` = 0 at a rising edge of `clk_ab` clears the A register to zero, and at a rising edge of `clk_ba` clears the B register to zero. The reset of one register leaves the other untouched.
- R10: With the stored source selected on a driven port, a value captured into the opposite register appears on that port immediately after the capture edge, with no further clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_ab | input | 1 | Capture clock of the A register (rising edge) |
| clk_ba | input | 1 | Capture clock of the B register (rising edge) |
| rst_n | input | 1 | Synchronous active-low reset, applied on each register's own clock |
| oe_n | input | 1 | Active-low output enable for both ports |
| dir | input | 1 | 0: port A driven, 1: port B driven |
| sel_ab | input | 1 | Source for port B: 0 live `a_in`, 1 A register |
| sel_ba | input | 1 | Source for port A: 0 live `b_in`, 1 B register |
| a_in | input | WIDTH | External data at port A |
| a_out | output | WIDTH | Data the block drives onto port A (zero when released) |
| a_oe | output | 1 | Port A is driven by the block |
| b_in | input | WIDTH | External data at port B |
| b_out | output | WIDTH | Data the block drives onto port B (zero when released) |
| b_oe | output | 1 | Port B is driven by the block |

## Verification
The bench builds the block with its default width of 8. This width lets alternating, all-ones and single-nibble patterns reach every bit lane of both registers and both output multiplexers with a small vector table. The loaded register values are distinct bytes, and every live input pattern differs from both of them, so a wrong source choice or a swapped register shows up as a byte mismatch rather than as a coincidental match. The feedback capture of a driven port (R8) and the one-sided reset (R9) are reachable at this width because the external input and the driven value are given different bytes.

// File: rtl/regbus_pkg.sv
package regbus_pkg;

    // Which port the block currently drives.
    typedef enum logic [1:0] {
        DRV_NONE = 2'd0,
        DRV_A    = 2'd1,
        DRV_B    = 2'd2
    } drive_e;

endpackage

// File: rtl/rbx_decode.sv
module rbx_decode
    import regbus_pkg::*;
(
    input  logic   oe_n,
    input  logic   dir,
    output drive_e drive,
    output logic   a_oe,
    output logic   b_oe
);

    always_comb begin
        if (oe_n) begin
            drive = DRV_NONE;
        end else if (dir) begin
            drive = DRV_B;
        end else begin
            drive = DRV_A;
        end
        a_oe = (drive == DRV_A);
        b_oe = (drive == DRV_B);
    end

endmodule

// File: rtl/rbx_capture.sv
module rbx_capture #(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] port_val,
    output logic [WIDTH-1:0] stored
);

    typedef struct packed {
        logic [WIDTH-1:0] data;
    } cap_t;

    cap_t cap_d;
    cap_t cap_q;

    always_comb begin
        cap_d = cap_q;
        if (!rst_n) begin
            cap_d.data = '0;
        end else begin
            cap_d.data = port_val;
        end
    end

    always_ff @(posedge clk) begin
        cap_q <= cap_d;
    end

    assign stored = cap_q.data;

endmodule

// File: rtl/rbx_out_mux.sv
module rbx_out_mux #(
    parameter int WIDTH = 8
) (
    input  logic             drive_en,
    input  logic             use_stored,
    input  logic [WIDTH-1:0] live_val,
    input  logic [WIDTH-1:0] stored_val,
    output logic [WIDTH-1:0] out_val
);

    always_comb begin
        if (!drive_en) begin
            out_val = '0;
        end else if (use_stored) begin
            out_val = stored_val;
        end else begin
            out_val = live_val;
        end
    end

endmodule

// File: rtl/regbus_xcvr.sv
module regbus_xcvr
    import regbus_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic             clk_ab,
    input  logic             clk_ba,
    input  logic             rst_n,
    input  logic             oe_n,
    input  logic             dir,
    input  logic             sel_ab,
    input  logic             sel_ba,
    input  logic [WIDTH-1:0] a_in,
    output logic [WIDTH-1:0] a_out,
    output logic             a_oe,
    input  logic [WIDTH-1:0] b_in,
    output logic [WIDTH-1:0] b_out,
    output logic             b_oe
);

    drive_e           drive;
    logic [WIDTH-1:0] q_a;
    logic [WIDTH-1:0] q_b;
    logic [WIDTH-1:0] a_port;
    logic [WIDTH-1:0] b_port;

    rbx_decode u_decode (
        .oe_n  (oe_n),
        .dir   (dir),
        .drive (drive),
        .a_oe  (a_oe),
        .b_oe  (b_oe)
    );

    // Value actually present on each port: own output while driven.
    assign a_port = a_oe ? a_out : a_in;
    assign b_port = b_oe ? b_out : b_in;

    rbx_capture #(.WIDTH(WIDTH)) u_cap_a (
        .clk      (clk_ab),
        .rst_n    (rst_n),
        .port_val (a_port),
        .stored   (q_a)
    );

    rbx_capture #(.WIDTH(WIDTH)) u_cap_b (
        .clk      (clk_ba),
        .rst_n    (rst_n),
        .port_val (b_port),
        .stored   (q_b)
    );

    // Port B shows live A or the A register.
    rbx_out_mux #(.WIDTH(WIDTH)) u_mux_b (
        .drive_en   (b_oe),
        .use_stored (sel_ab),
        .live_val   (a_in),
        .stored_val (q_a),
        .out_val    (b_out)
    );

    // Port A shows live B or the B register.
    rbx_out_mux #(.WIDTH(WIDTH)) u_mux_a (
        .drive_en   (a_oe),
        .use_stored (sel_ba),
        .live_val   (b_in),
        .stored_val (q_b),
        .out_val    (a_out)
    );

endmodule

// File: rtl/rbx_checker.sv
module rbx_checker #(
    parameter int WIDTH = 8
) (
    input logic             clk_ab,
    input logic             clk_ba,
    input logic             rst_n,
    input logic             oe_n,
    input logic             dir,
    input logic             sel_ab,
    input logic             sel_ba,
    input logic [WIDTH-1:0] a_in,
    input logic [WIDTH-1:0] a_out,
    input logic             a_oe,
    input logic [WIDTH-1:0] b_in,
    input logic [WIDTH-1:0] b_out,
    input logic             b_oe,
    input logic [WIDTH-1:0] q_a,
    input logic [WIDTH-1:0] q_b
);

    AST_RELEASED_IDLE: assert property (@(posedge clk_ab) disable iff (!rst_n)
        oe_n |-> (!a_oe && !b_oe && a_out == '0 && b_out == '0)); // R1

    AST_ONE_SIDE_DRIVEN: assert property (@(posedge clk_ba) disable iff (!rst_n)
        !oe_n |-> ((a_oe == !dir) && (b_oe == dir))); // R2

    AST_B_SOURCE: assert property (@(posedge clk_ab) disable iff (!rst_n)
        b_oe |-> (b_out == (sel_ab ? q_a : a_in))); // R3

    AST_A_SOURCE: assert property (@(posedge clk_ba) disable iff (!rst_n)
        a_oe |-> (a_out == (sel_ba ? q_b : b_in))); // R4

    AST_A_LOADS_PORT: assert property (@(posedge clk_ab) disable iff (!rst_n)
        $past(rst_n) |-> (q_a == $past(a_oe ? a_out : a_in))); // R5 R8

    AST_B_LOADS_PORT: assert property (@(posedge clk_ba) disable iff (!rst_n)
        $past(rst_n) |-> (q_b == $past(b_oe ? b_out : b_in))); // R5 R8

endmodule

bind regbus_xcvr rbx_checker #(.WIDTH(WIDTH)) u_chk (.*);

// File: tb/sim_regbus_xcvr.sv
`timescale 1ns/1ps
module sim_regbus_xcvr;

    localparam int W = 8;

    logic         clk = 1'b0;
    logic         clk_ab = 1'b0;
    logic         clk_ba = 1'b0;
    logic         rst_n = 1'b0;
    logic         oe_n = 1'b1;
    logic         dir = 1'b0;
    logic         sel_ab = 1'b0;
    logic         sel_ba = 1'b0;
    logic [W-1:0] a_in = '0;
    logic [W-1:0] b_in = '0;
    logic [W-1:0] a_out;
    logic [W-1:0] b_out;
    logic         a_oe;
    logic         b_oe;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    regbus_xcvr #(.WIDTH(W)) u0 (
        .clk_ab (clk_ab), .clk_ba (clk_ba), .rst_n (rst_n),
        .oe_n (oe_n), .dir (dir), .sel_ab (sel_ab), .sel_ba (sel_ba),
        .a_in (a_in), .a_out (a_out), .a_oe (a_oe),
        .b_in (b_in), .b_out (b_out), .b_oe (b_oe)
    );

    typedef struct packed {
        logic         oe_n;
        logic         dir;
        logic         s_ab;
        logic         s_ba;
        logic [W-1:0] a;
        logic [W-1:0] b;
        logic         e_aoe;
        logic         e_boe;
        logic [W-1:0] e_aout;
        logic [W-1:0] e_bout;
    } vec_t;

    // Registers preloaded with A=0x5A, B=0xC3 before this table is walked.
    localparam vec_t TBL [8] = '{
        '{1'b1, 1'b0, 1'b0, 1'b0, 8'h11, 8'h22, 1'b0, 1'b0, 8'h00, 8'h00}, // R1
        '{1'b1, 1'b1, 1'b1, 1'b1, 8'h33, 8'h44, 1'b0, 1'b0, 8'h00, 8'h00}, // R1
        '{1'b0, 1'b1, 1'b0, 1'b0, 8'h3C, 8'hFF, 1'b0, 1'b1, 8'h00, 8'h3C}, // R2 R3
        '{1'b0, 1'b1, 1'b1, 1'b0, 8'h3C, 8'hFF, 1'b0, 1'b1, 8'h00, 8'h5A}, // R3
        '{1'b0, 1'b0, 1'b0, 1'b0, 8'h77, 8'h81, 1'b1, 1'b0, 8'h81, 8'h00}, // R2 R4
        '{1'b0, 1'b0, 1'b0, 1'b1, 8'h77, 8'h81, 1'b1, 1'b0, 8'hC3, 8'h00}, // R4
        '{1'b0, 1'b0, 1'b1, 1'b0, 8'hAA, 8'h0F, 1'b1, 1'b0, 8'h0F, 8'h00}, // R4
        '{1'b0, 1'b1, 1'b0, 1'b1, 8'hE1, 8'h0F, 1'b0, 1'b1, 8'h00, 8'hE1}  // R3
    };

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic set_ctl(input logic o, input logic d, input logic sab, input logic sba,
                           input logic [W-1:0] av, input logic [W-1:0] bv);
        @(negedge clk);
        oe_n = o; dir = d; sel_ab = sab; sel_ba = sba; a_in = av; b_in = bv;
        #1;
    endtask

    task automatic pulse_ab();
        @(negedge clk); clk_ab = 1'b1;
        @(negedge clk); clk_ab = 1'b0;
        #1;
    endtask

    task automatic pulse_ba();
        @(negedge clk); clk_ba = 1'b1;
        @(negedge clk); clk_ba = 1'b0;
        #1;
    endtask

    // Bring out the A register on port B, and the B register on port A.
    task automatic peek_a(input string req, input logic [W-1:0] exp);
        set_ctl(1'b0, 1'b1, 1'b1, 1'b0, 8'h00, 8'h00);
        check(req, {8'h00, b_out}, {8'h00, exp});
    endtask

    task automatic peek_b(input string req, input logic [W-1:0] exp);
        set_ctl(1'b0, 1'b0, 1'b0, 1'b1, 8'h00, 8'h00);
        check(req, {8'h00, a_out}, {8'h00, exp});
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog actual=running expected=finished");
        finish_run();
    end

    initial begin
        // R9: reset clears both registers even with all-ones on the ports
        rst_n = 1'b0;
        set_ctl(1'b1, 1'b0, 1'b0, 1'b0, 8'hFF, 8'hFF);
        pulse_ab();
        pulse_ba();
        check("R1 reset a_oe/b_oe", {14'd0, a_oe, b_oe}, 16'd0);
        rst_n = 1'b1;
        peek_a("R9 reset A register", 8'h00);
        peek_b("R9 reset B register", 8'h00);

        // R5 R6: load with both ports released and selects high
        set_ctl(1'b1, 1'b1, 1'b1, 1'b1, 8'h5A, 8'hC3);
        pulse_ab();
        pulse_ba();
        peek_a("R6 A load while released", 8'h5A);
        peek_b("R6 B load while released", 8'hC3);

        // Vector table: control combinations against the stored 5A/C3
        for (int i = 0; i < 8; i++) begin
            set_ctl(TBL[i].oe_n, TBL[i].dir, TBL[i].s_ab, TBL[i].s_ba, TBL[i].a, TBL[i].b);
            check($sformatf("R1-R4 vec%0d enables", i), {14'd0, a_oe, b_oe},
                  {14'd0, TBL[i].e_aoe, TBL[i].e_boe});
            check($sformatf("R1-R4 vec%0d data", i), {a_out, b_out},
                  {TBL[i].e_aout, TBL[i].e_bout});
        end

        // R7: live pass-through with changing inputs, no capture edges
        set_ctl(1'b0, 1'b1, 1'b0, 1'b0, 8'h01, 8'h00);
        set_ctl(1'b0, 1'b1, 1'b0, 1'b0, 8'hFE, 8'h00);
        check("R7 live pass-through B", {8'h00, b_out}, 16'h00FE);
        set_ctl(1'b0, 1'b0, 1'b0, 1'b0, 8'h00, 8'h99);
        peek_a("R7 A register kept", 8'h5A);
        peek_b("R7 B register kept", 8'hC3);

        // R5: clk_ba leaves A register alone, clk_ab leaves B register alone
        set_ctl(1'b1, 1'b0, 1'b0, 1'b0, 8'h12, 8'h34);
        pulse_ba();
        peek_a("R5 A untouched by clk_ba", 8'h5A);
        peek_b("R5 B loaded by clk_ba", 8'h34);

        // R10: stored value on B straight after the capture edge
        set_ctl(1'b0, 1'b1, 1'b1, 1'b0, 8'h96, 8'h00);
        @(negedge clk); clk_ab = 1'b1; #1;
        check("R10 B shows new A register", {8'h00, b_out}, 16'h0096);
        @(negedge clk); clk_ab = 1'b0;
        // R10 other direction
        set_ctl(1'b0, 1'b0, 1'b0, 1'b1, 8'h00, 8'h69);
        @(negedge clk); clk_ba = 1'b1; #1;
        check("R10 A shows new B register", {8'h00, a_out}, 16'h0069);
        @(negedge clk); clk_ba = 1'b0;

        // R8: driven port captures its own output, not its input vector
        set_ctl(1'b0, 1'b0, 1'b0, 1'b0, 8'h11, 8'h3E);
        pulse_ab();
        peek_a("R8 A captures driven value", 8'h3E);
        set_ctl(1'b0, 1'b1, 1'b0, 1'b0, 8'h71, 8'h22);
        pulse_ba();
        peek_b("R8 B captures driven value", 8'h71);

        // R9: one-sided reset leaves the other register intact
        rst_n = 1'b0;
        pulse_ab();
        rst_n = 1'b1;
        peek_a("R9 A cleared", 8'h00);
        peek_b("R9 B kept", 8'h71);

        finish_run();
    end

endmodule